// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

A clocked memory of 18-bit words split into two 9-bit byte lanes, used as local storage by a processor or a memory controller that works in four-word bursts. An access begins when one of two address strobes is accepted. The first strobe is reserved for the processor and is honoured only while the first chip enable is active. The second strobe belongs to the controller and has no chip-enable gate. When a strobe is accepted, the address and the three chip enables are captured. If the chip enables select the device, a burst starts. If they do not, the device becomes deselected.

During a burst, a 2-bit counter supplies the two low address bits. It steps on each cycle in which the advance input is low. A static order input selects a linear order (start plus step, modulo four) or an interleaved order (start XOR step). Writes can cover the whole word or individual lanes. Read data passes through one output register, so it appears one clock after the access.

There is no real tri-state pin. The block gives a registered data value and a drive flag. Output enable acts on the drive flag without a clock. The flag is held low for the first read cycle after a deselected state. A sleep input freezes every register and keeps the memory contents.

Top module: `burst_sram`

## Requirements
- R1: After reset the device is deselected, `dout_en` is 0 and `dout` is 0.
- R2: A strobe is accepted and starts a burst only when `ce1_n`=0, `ce2`=1 and `ce3_n`=0. An accepted strobe with any other enable combination deselects the device. A deselected device performs no write and raises no read flag.
- R3: If both strobes are low and `ce1_n`=0, the processor strobe is taken. A cycle taken through the processor strobe is always a read and ignores every write control.
- R4: The processor strobe is ignored while `ce1_n`=1. An active burst then continues as if no strobe were present. The controller strobe is accepted whatever `ce1_n` is.
- R5: An accepted strobe loads `addr[1:0]` as the burst start with step 0. The first access uses the captured address. Each later cycle with `adv_n`=0 and no strobe moves to the next step. With `order_sel`=0 the low bits are start+step modulo 4.
- R6: With `order_sel`=1 the low bits are start XOR step.
- R7: A burst cycle with `adv_n`=1 and no strobe accesses the same address again.
- R8: The counter wraps inside the aligned 4-word block. Bits above bit 1 of the captured address never change during a burst.
- R9: `gw_n`=0 in a write-capable cycle writes all 18 bits, whatever `bwe_n` and `bsel_n` are.
- R10: With `gw_n`=1 and `bwe_n`=0, each lane whose `bsel_n` bit is 0 is written. Bit 0 selects `din[8:0]` and bit 1 selects `din[17:9]`. Lanes whose bit is 1 keep their contents. With `gw_n`=1 and `bwe_n`=1 the cycle is a read.
- R11: `dout` holds the word read at the previous rising edge.
- R12: `dout_en` is 1 only while a read result is held and `oe_n` is 0. It follows `oe_n` without waiting for a clock edge.
- R13: For the read result of the first access after a deselected state, `dout_en` stays 0 even with `oe_n`=0.
- R14: While `sleep`=1, `dout_en` is 0. No strobe, advance or write has any effect, and the memory keeps its contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | Word address, captured on an accepted strobe |
| ce1_n | input | 1 | Chip enable 1, active low; also gates the processor strobe |
| ce2 | input | 1 | Chip enable 2, active high |
| ce3_n | input | 1 | Chip enable 3, active low |
| strb_p_n | input | 1 | Processor address strobe, active low |
| strb_c_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bsel_n | input | LANES | Per-lane byte selects, active low |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| order_sel | input | 1 | Burst order: 0 linear, 1 interleaved (static) |
| sleep | input | 1 | Sleep, active high |
| din | input | LANES*LANE_W | Write data |
| dout | output | LANES*LANE_W | Registered read data |
| dout_en | output | 1 | Drive flag for the read data |

## Verification
A write lands in the array at the rising edge where it is sampled. Read data and its read flag appear right after the access edge. The bench therefore drives inputs one time unit after a rising edge and compares `dout` one time unit after the next rising edge. Each burst cycle is thus checked against the address that cycle accessed. The output-enable tests change `oe_n` between edges and look at `dout_en` one time unit later, with no clock in between. The sleep tests look at the flag during sleep, then read back the targeted address after waking.

// File: rtl/burst_sram.sv
module burst_sram #(
  parameter int ADDR_W = 10,
  parameter int LANE_W = 9,
  parameter int LANES  = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ADDR_W-1:0]         addr,
  input  logic                      ce1_n,
  input  logic                      ce2,
  input  logic                      ce3_n,
  input  logic                      strb_p_n,
  input  logic                      strb_c_n,
  input  logic                      adv_n,
  input  logic                      gw_n,
  input  logic                      bwe_n,
  input  logic [LANES-1:0]          bsel_n,
  input  logic                      oe_n,
  input  logic                      order_sel,
  input  logic                      sleep,
  input  logic [LANES*LANE_W-1:0]   din,
  output logic [LANES*LANE_W-1:0]   dout,
  output logic                      dout_en
);
  localparam int DATA_W = LANES * LANE_W;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int HI_W   = ADDR_W - 2;

  logic [DATA_W-1:0] mem [DEPTH];

  logic            active_q, rd_q, first_q;
  logic [1:0]      cnt_q, start_q;
  logic [HI_W-1:0] base_q;
  logic [DATA_W-1:0] dout_q;

  logic p_hit, c_hit, load, sel, cont, step, acc, is_wr, rd_acc;
  logic [1:0]        cnt_nxt, start_nxt, low;
  logic [HI_W-1:0]   base_nxt;
  logic [ADDR_W-1:0] acc_addr;
  logic [LANES-1:0]  lane_we;

  assign p_hit = !sleep && !strb_p_n && !ce1_n;
  assign c_hit = !sleep && !strb_c_n && !p_hit;
  assign load  = p_hit || c_hit;
  assign sel   = !ce1_n && ce2 && !ce3_n;
  assign cont  = !sleep && !load && active_q;
  assign step  = cont && !adv_n;

  assign cnt_nxt   = load ? 2'd0 : (step ? cnt_q + 2'd1 : cnt_q);
  assign start_nxt = load ? addr[1:0] : start_q;
  assign base_nxt  = load ? addr[ADDR_W-1:2] : base_q;
  assign low       = order_sel ? (start_nxt ^ cnt_nxt) : (start_nxt + cnt_nxt);
  assign acc_addr  = {base_nxt, low};

  assign acc    = (load && sel) || cont;
  assign is_wr  = !p_hit && (!gw_n || !bwe_n);
  assign rd_acc = acc && !is_wr;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_we[l] = acc && !p_hit && (!gw_n || (!bwe_n && !bsel_n[l]));
    always_ff @(posedge clk) begin
      if (lane_we[l])
        mem[acc_addr][l*LANE_W +: LANE_W] <= din[l*LANE_W +: LANE_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      rd_q     <= 1'b0;
      first_q  <= 1'b0;
      cnt_q    <= '0;
      start_q  <= '0;
      base_q   <= '0;
      dout_q   <= '0;
    end else if (!sleep) begin
      if (load) active_q <= sel;
      cnt_q   <= cnt_nxt;
      start_q <= start_nxt;
      base_q  <= base_nxt;
      rd_q    <= rd_acc;
      first_q <= rd_acc && !active_q;
      if (rd_acc) dout_q <= mem[acc_addr];
    end
  end

  assign dout    = dout_q;
  assign dout_en = rd_q && !first_q && !oe_n && !sleep;
endmodule

module burst_sram_chk #(
  parameter int DW = 18
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sleep,
  input logic          oe_n,
  input logic          strb_p_n,
  input logic          strb_c_n,
  input logic          ce1_n,
  input logic          ce2,
  input logic          ce3_n,
  input logic          gw_n,
  input logic          bwe_n,
  input logic          active,
  input logic          dout_en,
  input logic [DW-1:0] dout
);
  logic taken, selected;
  assign taken    = !sleep && ((!strb_p_n && !ce1_n) || !strb_c_n);
  assign selected = !ce1_n && ce2 && !ce3_n;

  // R12
  oe_gates_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dout_en |-> !oe_n);

  // R14
  sleep_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> !dout_en);

  // R14
  sleep_holds_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> $stable(dout));

  // R2
  deselect_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (taken && !selected) |=> !dout_en);

  // R13
  first_read_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (taken && selected && !active && (!strb_p_n && !ce1_n || (gw_n && bwe_n))) |=> !dout_en);
endmodule

bind burst_sram burst_sram_chk #(.DW(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .sleep(sleep), .oe_n(oe_n),
  .strb_p_n(strb_p_n), .strb_c_n(strb_c_n),
  .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
  .gw_n(gw_n), .bwe_n(bwe_n), .active(active_q),
  .dout_en(dout_en), .dout(dout)
);

// File: tb/burst_sram_tb.sv
module burst_sram_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic ce1_n = 1'b0, ce2 = 1'b1, ce3_n = 1'b0;
  logic strb_p_n = 1'b1, strb_c_n = 1'b1, adv_n = 1'b1;
  logic gw_n = 1'b1, bwe_n = 1'b1;
  logic [1:0] bsel_n = 2'b11;
  logic oe_n = 1'b0, order_sel = 1'b0, sleep = 1'b0;
  logic [17:0] din = '0;
  logic [17:0] dout;
  logic dout_en;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_sram #(.ADDR_W(AW), .LANE_W(9), .LANES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
    .strb_p_n(strb_p_n), .strb_c_n(strb_c_n), .adv_n(adv_n), .gw_n(gw_n),
    .bwe_n(bwe_n), .bsel_n(bsel_n), .oe_n(oe_n), .order_sel(order_sel),
    .sleep(sleep), .din(din), .dout(dout), .dout_en(dout_en)
  );

  function automatic logic [17:0] pat(input logic [AW-1:0] a);
    return 18'h0A000 + 18'(a);
  endfunction

  task automatic check(input string req, input logic [17:0] act, input logic [17:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic idle();
    strb_p_n = 1; strb_c_n = 1; adv_n = 1; gw_n = 1; bwe_n = 1; bsel_n = 2'b11;
    ce1_n = 0; ce2 = 1; ce3_n = 0; oe_n = 0; sleep = 0;
  endtask

  task automatic deselect();
    idle(); strb_c_n = 0; ce2 = 0; cyc(); idle();
  endtask

  task automatic write_word(input logic [AW-1:0] a, input logic [17:0] d);
    idle(); addr = a; strb_c_n = 0; gw_n = 0; din = d; cyc();
    deselect();
  endtask

  task automatic read_word(input string req, input logic [AW-1:0] a, input logic [17:0] exp);
    idle(); addr = a; strb_p_n = 0; cyc();
    check(req, dout, exp);
    deselect();
  endtask

  task automatic t_reset();
    check("R1 dout_en", {17'd0, dout_en}, 18'd0);
    check("R1 dout", dout, 18'd0);
  endtask

  task automatic t_burst_write();
    logic [1:0] lows [4] = '{2'd1, 2'd2, 2'd3, 2'd0};
    idle(); addr = 10'h021; strb_c_n = 0; gw_n = 0; din = pat(10'h021); cyc();
    strb_c_n = 1; adv_n = 0;
    for (int i = 1; i < 4; i++) begin
      din = pat({8'h08, lows[i]}); cyc();
    end
    deselect();
    read_word("R8 no carry into bit 2", 10'h024, 18'h00000 | 18'h0);
  endtask

  task automatic t_linear_read();
    logic [AW-1:0] seq [5] = '{10'h021, 10'h022, 10'h023, 10'h020, 10'h021};
    idle(); order_sel = 0; addr = 10'h021; strb_p_n = 0; cyc();
    check("R11 first word", dout, pat(seq[0]));
    check("R13 masked first read", {17'd0, dout_en}, 18'd0);
    strb_p_n = 1; adv_n = 0;
    for (int i = 1; i < 5; i++) begin
      cyc();
      check(i == 4 ? "R8 wrap" : "R5 linear step", dout, pat(seq[i]));
      check("R12 drive on", {17'd0, dout_en}, 18'd1);
    end
    oe_n = 1; #1;
    check("R12 oe async off", {17'd0, dout_en}, 18'd0);
    oe_n = 0; #1;
    check("R12 oe async on", {17'd0, dout_en}, 18'd1);
    deselect();
    check("R2 deselect drops flag", {17'd0, dout_en}, 18'd0);
  endtask

  task automatic t_interleaved_read();
    logic [AW-1:0] seq [4] = '{10'h021, 10'h020, 10'h023, 10'h022};
    idle(); order_sel = 1; addr = 10'h021; strb_p_n = 0; cyc();
    check("R6 start", dout, pat(seq[0]));
    strb_p_n = 1; adv_n = 0;
    for (int i = 1; i < 4; i++) begin
      cyc();
      check("R6 interleaved step", dout, pat(seq[i]));
    end
    deselect(); order_sel = 0;
  endtask

  task automatic t_hold_and_gate();
    idle(); addr = 10'h022; strb_p_n = 0; cyc();
    strb_p_n = 1; adv_n = 1; cyc();
    check("R7 hold address", dout, pat(10'h022));
    check("R13 second read drives", {17'd0, dout_en}, 18'd1);
    adv_n = 0; strb_p_n = 0; ce1_n = 1; cyc();
    check("R4 gated strobe, burst continues", dout, pat(10'h023));
    check("R4 still driving", {17'd0, dout_en}, 18'd1);
    strb_p_n = 1; strb_c_n = 0; cyc();
    check("R4 controller strobe with ce1 high deselects", {17'd0, dout_en}, 18'd0);
    idle();
  endtask

  task automatic t_unselected_write();
    idle(); addr = 10'h021; strb_c_n = 0; ce3_n = 1; gw_n = 0; din = 18'h3FFFF; cyc();
    idle();
    read_word("R2 unselected write ignored", 10'h021, pat(10'h021));
  endtask

  task automatic t_priority();
    write_word(10'h040, 18'h15555);
    idle(); addr = 10'h040; strb_p_n = 0; strb_c_n = 0; gw_n = 0; din = 18'h2AAAA; cyc();
    check("R3 processor cycle reads", dout, 18'h15555);
    deselect();
    read_word("R3 no write on processor cycle", 10'h040, 18'h15555);
  endtask

  task automatic t_byte_writes();
    write_word(10'h030, {9'h152, 9'h1A5});
    idle(); addr = 10'h030; strb_c_n = 0; bwe_n = 0; bsel_n = 2'b10; din = {9'h0FF, 9'h123}; cyc();
    deselect();
    read_word("R10 lane 0 only", 10'h030, {9'h152, 9'h123});
    idle(); addr = 10'h030; strb_c_n = 0; bwe_n = 0; bsel_n = 2'b01; din = {9'h0C3, 9'h000}; cyc();
    deselect();
    read_word("R10 lane 1 only", 10'h030, {9'h0C3, 9'h123});
    idle(); addr = 10'h030; strb_c_n = 0; bwe_n = 1; bsel_n = 2'b00; din = 18'h3FFFF; cyc();
    check("R10 bwe high reads", dout, {9'h0C3, 9'h123});
    deselect();
    idle(); addr = 10'h030; strb_c_n = 0; gw_n = 0; bwe_n = 1; bsel_n = 2'b11; din = 18'h1E1E1; cyc();
    deselect();
    read_word("R9 global write", 10'h030, 18'h1E1E1);
  endtask

  task automatic t_sleep();
    idle(); addr = 10'h040; strb_p_n = 0; cyc();
    strb_p_n = 1; cyc();
    sleep = 1; #1;
    check("R14 flag low in sleep", {17'd0, dout_en}, 18'd0);
    strb_c_n = 0; gw_n = 0; din = 18'h00777; cyc();
    check("R14 flag low after sleep edge", {17'd0, dout_en}, 18'd0);
    check("R14 output held", dout, 18'h15555);
    idle(); deselect();
    read_word("R14 contents kept", 10'h040, 18'h15555);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    write_word(10'h024, 18'h0);
    t_burst_write();
    t_linear_read();
    t_interleaved_read();
    t_hold_and_gate();
    t_unselected_write();
    t_priority();
    t_byte_writes();
    t_sleep();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule